// File: doc/BRIEF.md
# DMA Channel Address and Count Unit

This block keeps the per-channel transfer state of a four-channel DMA engine. Each channel owns a base and a current 16-bit address, and a base and a current 16-bit count. Writing a base value also writes the matching current value. After that, every transfer step on a channel moves its current address by one, up or down as the channel's mode selects, and lowers its current count by one.

The count is programmed as the number of transfers minus one. A transfer therefore ends on the step taken while the count is zero, when the count underflows. This terminal count sets a sticky per-channel flag and produces a one-cycle end-of-process pulse. A transfer can also be ended early by an external end-of-process input. At either kind of end, a channel in auto-initialize mode reloads its current registers from the base registers and stays enabled. A channel without auto-initialize masks itself.

The surrounding engine selects a channel, strobes steps and reads back that channel's current address and count. Bus sequencing and the processor register interface sit outside this block.

Top module: `dma_acu`

## Requirements
- R1: After reset every channel is masked (`ch_active` = 0), all `tc_flags` are 0, `eop_out` is 0, and every base and current address and count is 0.
- R2: A write of `cfg_data` to a channel's address (`cfg_addr_we`) or count (`cfg_cnt_we`) sets both the base and the current register. The new value is visible on `view_addr` / `view_cnt` after the clock edge. A write takes priority over a step to the same channel in the same cycle.
- R3: With mode bit `cfg_down` = 0, each step adds 1 to the current address, and 16'hFFFF wraps to 16'h0000.
- R4: With mode bit `cfg_down` = 1, each step subtracts 1 from the current address, and 16'h0000 wraps to 16'hFFFF.
- R5: Each step subtracts 1 from the current count. A count programmed as N-1 yields exactly N steps. Terminal count happens on the Nth step, the one taken while the count reads 0.
- R6: Terminal count sets `tc_flags[i]`. The flag stays set until a cycle with `tc_clr[i]` = 1 clears it. If a set and a clear meet in the same cycle, the set wins.
- R7: `eop_out` is 1 for exactly one cycle: the cycle right after the terminal-count step's clock edge.
- R8: With mode bit `cfg_auto` = 0, terminal count masks the channel. The count then reads 16'hFFFF and the address reads one step past its last value.
- R9: With `cfg_auto` = 1, terminal count reloads the current address and count from the base registers, and the channel stays active.
- R10: `eop_in` = 1 on the active channel selected by `xfer_sel` ends its transfer: it reloads with `cfg_auto` = 1 and masks with `cfg_auto` = 0. It neither sets `tc_flags` nor pulses `eop_out`.
- R11: Steps and `eop_in` aimed at a masked channel are ignored: its address, count and flag do not change. `cfg_unmask` re-enables the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel | input | 2 | Channel targeted by configuration writes |
| cfg_addr_we | input | 1 | Write `cfg_data` to base and current address |
| cfg_cnt_we | input | 1 | Write `cfg_data` to base and current count |
| cfg_data | input | 16 | Value for address or count writes |
| cfg_mode_we | input | 1 | Write `cfg_down` and `cfg_auto` into the channel mode |
| cfg_down | input | 1 | Mode: 1 = address counts down, 0 = up |
| cfg_auto | input | 1 | Mode: 1 = auto-initialize at end of transfer |
| cfg_unmask | input | 1 | Enable the channel at `cfg_sel` |
| xfer_sel | input | 2 | Channel being serviced; also selects the view outputs |
| xfer_step | input | 1 | One transfer step on `xfer_sel` |
| eop_in | input | 1 | External end-of-process for `xfer_sel` |
| tc_clr | input | 4 | Per-channel clear of the terminal-count flag |
| view_addr | output | 16 | Current address of `xfer_sel` |
| view_cnt | output | 16 | Current count of `xfer_sel` |
| tc_flags | output | 4 | Sticky terminal-count flags |
| ch_active | output | 4 | Channel enabled (unmasked) |
| eop_out | output | 1 | One-cycle end-of-process pulse after terminal count |

## Verification
The hardest states to reach are the ones where several effects meet in one cycle. One is the terminal-count step that lands on an address wrap in either direction. Another is a flag clear that coincides with a new terminal count. A third is an external stop that arrives between steps. The bench reaches them by sweeping every channel through every combination of direction and auto-initialize with lengths of one to three transfers. Each transfer starts one address away from the 16-bit boundary, so the wrap falls inside the short transfer. Directed sequences then force the coincident clear and both variants of the external stop.

// File: rtl/dma_acu_pkg.sv
package dma_acu_pkg;

    localparam int DEF_CH = 4;
    localparam int DEF_AW = 16;
    localparam int DEF_CW = 16;

    typedef struct packed {
        logic auto_init;
        logic down;
    } ch_mode_t;

    typedef enum logic [1:0] {
        END_NONE  = 2'd0,
        END_COUNT = 2'd1,
        END_EXT   = 2'd2
    } end_kind_t;

    function automatic end_kind_t classify_end(input logic count_out, input logic ext_stop);
        if (count_out)
            return END_COUNT;
        else if (ext_stop)
            return END_EXT;
        else
            return END_NONE;
    endfunction

endpackage

// File: rtl/dma_acu_chregs.sv
module dma_acu_chregs #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_addr,
    input  logic [AW-1:0] addr_data,
    input  logic          wr_cnt,
    input  logic [CW-1:0] cnt_data,
    input  logic          step,
    input  logic          down,
    input  logic          reload,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] cur_cnt,
    output logic          cnt_zero
);
    localparam logic [AW-1:0] A_ONE = {{(AW-1){1'b0}}, 1'b1};
    localparam logic [CW-1:0] C_ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [AW-1:0] base_addr;
    logic [CW-1:0] base_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            cur_addr  <= '0;
        end else if (wr_addr) begin
            base_addr <= addr_data;
            cur_addr  <= addr_data;
        end else if (reload) begin
            cur_addr  <= base_addr;
        end else if (step) begin
            cur_addr  <= down ? (cur_addr - A_ONE) : (cur_addr + A_ONE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_cnt <= '0;
            cur_cnt  <= '0;
        end else if (wr_cnt) begin
            base_cnt <= cnt_data;
            cur_cnt  <= cnt_data;
        end else if (reload) begin
            cur_cnt  <= base_cnt;
        end else if (step) begin
            cur_cnt  <= cur_cnt - C_ONE;
        end
    end

    assign cnt_zero = (cur_cnt == '0);

    // R3
    addr_up_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_addr && !reload && !down) |=> (cur_addr == $past(cur_addr) + A_ONE));

    // R4
    addr_down_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_addr && !reload && down) |=> (cur_addr == $past(cur_addr) - A_ONE));

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_cnt && !reload) |=> (cur_cnt == $past(cur_cnt) - C_ONE));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step && !wr_addr && !wr_cnt && !reload) |=> ($stable(cur_addr) && $stable(cur_cnt)));

endmodule

// File: rtl/dma_acu_chstate.sv
module dma_acu_chstate
    import dma_acu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_mode,
    input  ch_mode_t mode_in,
    input  logic     unmask,
    input  logic     count_out,
    input  logic     ext_stop,
    input  logic     clr,
    output ch_mode_t mode,
    output logic     active,
    output logic     tc_flag,
    output logic     reload
);
    end_kind_t end_kind;
    logic      term;

    always_comb begin
        end_kind = classify_end(count_out, ext_stop);
        term     = (end_kind != END_NONE);
        reload   = term && mode.auto_init;
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode <= '0;
        else if (wr_mode)
            mode <= mode_in;
    end

    always_ff @(posedge clk) begin
        if (rst)
            active <= 1'b0;
        else if (term && !mode.auto_init)
            active <= 1'b0;
        else if (unmask)
            active <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            tc_flag <= 1'b0;
        else if (end_kind == END_COUNT)
            tc_flag <= 1'b1;
        else if (clr)
            tc_flag <= 1'b0;
    end

    // R8
    self_mask_chk: assert property (@(posedge clk) disable iff (rst)
        ((count_out || ext_stop) && !mode.auto_init) |=> !active);

    // R9
    stay_on_chk: assert property (@(posedge clk) disable iff (rst)
        ((count_out || ext_stop) && mode.auto_init && active) |=> active);

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        count_out |=> tc_flag);

    // R10
    ext_noflag_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_stop && !count_out && !tc_flag) |=> !tc_flag);

endmodule

// File: rtl/dma_acu.sv
module dma_acu
    import dma_acu_pkg::*;
#(
    parameter int NUM_CH = DEF_CH,
    parameter int AW     = DEF_AW,
    parameter int CW     = DEF_CW,
    localparam int SW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int DW    = (AW > CW) ? AW : CW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SW-1:0]     cfg_sel,
    input  logic              cfg_addr_we,
    input  logic              cfg_cnt_we,
    input  logic [DW-1:0]     cfg_data,
    input  logic              cfg_mode_we,
    input  logic              cfg_down,
    input  logic              cfg_auto,
    input  logic              cfg_unmask,
    input  logic [SW-1:0]     xfer_sel,
    input  logic              xfer_step,
    input  logic              eop_in,
    input  logic [NUM_CH-1:0] tc_clr,
    output logic [AW-1:0]     view_addr,
    output logic [CW-1:0]     view_cnt,
    output logic [NUM_CH-1:0] tc_flags,
    output logic [NUM_CH-1:0] ch_active,
    output logic              eop_out
);
    logic [AW-1:0]     addr_arr [NUM_CH];
    logic [CW-1:0]     cnt_arr  [NUM_CH];
    logic [NUM_CH-1:0] count_out_vec;
    logic [NUM_CH-1:0] ext_vec;
    logic [NUM_CH-1:0] step_vec;
    ch_mode_t          mode_in;

    assign mode_in = '{auto_init: cfg_auto, down: cfg_down};

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic     cfg_hit;
        logic     xfer_hit;
        logic     cnt_zero;
        logic     reload;
        ch_mode_t mode;

        assign cfg_hit          = (cfg_sel == SW'(i));
        assign xfer_hit         = (xfer_sel == SW'(i)) && ch_active[i];
        assign step_vec[i]      = xfer_step && xfer_hit;
        assign count_out_vec[i] = step_vec[i] && cnt_zero;
        assign ext_vec[i]       = eop_in && xfer_hit;

        dma_acu_chregs #(.AW(AW), .CW(CW)) u_regs (
            .clk       (clk),
            .rst       (rst),
            .wr_addr   (cfg_addr_we && cfg_hit),
            .addr_data (cfg_data[AW-1:0]),
            .wr_cnt    (cfg_cnt_we && cfg_hit),
            .cnt_data  (cfg_data[CW-1:0]),
            .step      (step_vec[i]),
            .down      (mode.down),
            .reload    (reload),
            .cur_addr  (addr_arr[i]),
            .cur_cnt   (cnt_arr[i]),
            .cnt_zero  (cnt_zero)
        );

        dma_acu_chstate u_state (
            .clk       (clk),
            .rst       (rst),
            .wr_mode   (cfg_mode_we && cfg_hit),
            .mode_in   (mode_in),
            .unmask    (cfg_unmask && cfg_hit),
            .count_out (count_out_vec[i]),
            .ext_stop  (ext_vec[i]),
            .clr       (tc_clr[i]),
            .mode      (mode),
            .active    (ch_active[i]),
            .tc_flag   (tc_flags[i]),
            .reload    (reload)
        );
    end

    always_comb begin
        view_addr = addr_arr[xfer_sel];
        view_cnt  = cnt_arr[xfer_sel];
    end

    always_ff @(posedge clk) begin
        if (rst)
            eop_out <= 1'b0;
        else
            eop_out <= |count_out_vec;
    end

    // R7
    eop_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        eop_out |=> !eop_out);

    // R7
    eop_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(eop_out) |-> $past(xfer_step));

    // R11
    one_step_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(step_vec));

    // R10
    ext_no_eop_chk: assert property (@(posedge clk) disable iff (rst)
        (|ext_vec && !(|count_out_vec)) |=> !eop_out);

endmodule

// File: tb/dma_acu_bench.sv
module dma_acu_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  cfg_sel, xfer_sel;
    logic        cfg_addr_we, cfg_cnt_we, cfg_mode_we, cfg_down, cfg_auto, cfg_unmask;
    logic [15:0] cfg_data;
    logic        xfer_step, eop_in;
    logic [3:0]  tc_clr;
    logic [15:0] view_addr, view_cnt;
    logic [3:0]  tc_flags, ch_active;
    logic        eop_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dma_acu u_dma_acu (
        .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cfg_addr_we(cfg_addr_we),
        .cfg_cnt_we(cfg_cnt_we), .cfg_data(cfg_data), .cfg_mode_we(cfg_mode_we),
        .cfg_down(cfg_down), .cfg_auto(cfg_auto), .cfg_unmask(cfg_unmask),
        .xfer_sel(xfer_sel), .xfer_step(xfer_step), .eop_in(eop_in), .tc_clr(tc_clr),
        .view_addr(view_addr), .view_cnt(view_cnt), .tc_flags(tc_flags),
        .ch_active(ch_active), .eop_out(eop_out)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        cfg_addr_we = 0; cfg_cnt_we = 0; cfg_mode_we = 0; cfg_unmask = 0;
        xfer_step = 0; eop_in = 0; tc_clr = 0;
    endtask

    task automatic setup(input int c, input logic [15:0] a, input logic [15:0] n1,
                         input logic dn, input logic au);
        cfg_sel = 2'(c); xfer_sel = 2'(c);
        cfg_data = a; cfg_addr_we = 1; tick(); idle();
        check("R2 addr write", view_addr, a);
        cfg_data = n1; cfg_cnt_we = 1; tick(); idle();
        check("R2 cnt write", view_cnt, n1);
        cfg_down = dn; cfg_auto = au; cfg_mode_we = 1; cfg_unmask = 1; tick(); idle();
        check("R11 unmask", ch_active[c], 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(); cfg_sel = 0; xfer_sel = 0; cfg_data = 0; cfg_down = 0; cfg_auto = 0;
        rst = 1;
        tick(); tick();
        rst = 0;
        check("R1 active", ch_active, 4'h0);
        check("R1 flags", tc_flags, 4'h0);
        check("R1 eop", eop_out, 1'b0);
        for (int c = 0; c < 4; c++) begin
            xfer_sel = 2'(c); #1;
            check("R1 addr", view_addr, 16'h0);
            check("R1 cnt", view_cnt, 16'h0);
        end

        // R3 R4 R5 R6 R7 R8 R9 R11 sweep
        for (int c = 0; c < 4; c++)
        for (int dn = 0; dn < 2; dn++)
        for (int au = 0; au < 2; au++)
        for (int n = 1; n <= 3; n++) begin
            logic [15:0] start;
            logic [15:0] ea;
            start = dn ? 16'h0001 : 16'hFFFE;
            setup(c, start, 16'(n - 1), dn[0], au[0]);
            for (int k = 1; k <= n; k++) begin
                xfer_step = 1; tick(); idle();
                ea = dn ? start - 16'(k) : start + 16'(k);
                if (k < n) begin
                    check(dn ? "R4 addr step" : "R3 addr step", view_addr, ea);
                    check("R5 cnt step", view_cnt, 16'(n - 1 - k));
                    check("R7 no early eop", eop_out, 1'b0);
                    check("R5 no early tc", tc_flags[c], 1'b0);
                end else begin
                    check("R7 eop pulse", eop_out, 1'b1);
                    check("R6 tc set", tc_flags[c], 1'b1);
                    if (au) begin
                        check("R9 reload addr", view_addr, start);
                        check("R9 reload cnt", view_cnt, 16'(n - 1));
                        check("R9 stays active", ch_active[c], 1'b1);
                    end else begin
                        check(dn ? "R4 final addr" : "R3 final addr", view_addr, ea);
                        check("R8 cnt underflow", view_cnt, 16'hFFFF);
                        check("R8 masked", ch_active[c], 1'b0);
                    end
                end
            end
            tick();
            check("R7 eop single", eop_out, 1'b0);
            check("R6 tc held", tc_flags[c], 1'b1);
            if (!au) begin
                ea = view_addr;
                xfer_step = 1; tick(); idle();
                check("R11 masked addr", view_addr, ea);
                check("R11 masked cnt", view_cnt, 16'hFFFF);
            end
            tc_clr[c] = 1; tick(); idle();
            check("R6 tc cleared", tc_flags[c], 1'b0);
        end

        // R6 set beats clear
        setup(1, 16'h0100, 16'h0000, 1'b0, 1'b1);
        xfer_step = 1; tc_clr = 4'b0010; tick(); idle();
        check("R6 set wins", tc_flags[1], 1'b1);
        tc_clr = 4'b0010; tick(); idle();

        // R2 write beats step
        cfg_sel = 1; cfg_data = 16'h0abc; cfg_addr_we = 1; xfer_step = 1; tick(); idle();
        check("R2 write priority", view_addr, 16'h0abc);

        // R10 external stop, no auto
        setup(2, 16'h2000, 16'h0005, 1'b0, 1'b0);
        xfer_step = 1; tick(); idle();
        eop_in = 1; tick(); idle();
        check("R10 masked", ch_active[2], 1'b0);
        check("R10 addr kept", view_addr, 16'h2001);
        check("R10 no tc", tc_flags[2], 1'b0);
        check("R10 no eop", eop_out, 1'b0);
        eop_in = 1; tick(); idle();
        check("R11 masked eop ignored", view_cnt, 16'h0004);

        // R10 external stop, auto
        setup(3, 16'h3000, 16'h0007, 1'b1, 1'b1);
        xfer_step = 1; tick(); xfer_step = 1; tick(); idle();
        check("R4 two steps", view_addr, 16'h2FFE);
        eop_in = 1; tick(); idle();
        check("R10 reload addr", view_addr, 16'h3000);
        check("R10 reload cnt", view_cnt, 16'h0007);
        check("R10 still active", ch_active[3], 1'b1);
        check("R10 auto no tc", tc_flags[3], 1'b0);
        check("R10 auto no eop", eop_out, 1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule